// File: doc/BRIEF.md
# Runtime-Configurable Sum-of-Products Array

This block realises two Boolean functions of three inputs as sums of products. The products are built in an AND plane of four product lines. For each input, a product line can take the true form of that input, its inverted form, or leave it out. An OR plane then gives each output the OR of any subset of those lines. The path from the inputs to the outputs is purely combinational. Only the connection pattern is held in flops.

The connection pattern is loaded through a synchronous write port: a write enable, a row address and a data word. It can be rewritten at any time while the surrounding logic runs, so the same hardware can take on a new truth table between uses. Four product lines are fewer than the eight minterms of three inputs, so a function must fit in four products after minimisation. The array does not simply store each minterm.

Top module: `rt_pla`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no write since, every connection is cleared and both outputs read 0 for all eight input values.
- R2: An AND row holds a 2-bit code per input in bits [2i+1:2i] for input i. Code 01 includes that input in the product and code 10 includes its inverse.
- R3: Code 00 leaves the input out of the product. A row that is all 00 makes its product line 1 for every input value.
- R4: Code 11 in any field forces that product line to 0, whatever the other fields hold.
- R5: An OR row holds one bit per product line, with bit t standing for line t. Each output is the OR of the lines whose bits are set. An output with no bits set reads 0.
- R6: Row addresses 0 to 3 select the AND row of product line 0 to 3 and take data bits [5:0]. Address 4 selects the OR row of `z_o[0]` and address 5 the OR row of `z_o[1]`; both take data bits [3:0]. A write to address 6 or 7 changes nothing.
- R7: A write takes effect at the rising clock edge where `cfg_we_i` is high. Before that edge the outputs still show the old function.
- R8: The outputs follow a change on `x_i` in the same cycle, with no clock edge in between.
- R9: When loaded with lines x2'x1'x0, x2'x1x0, x2x1'x0' and x2x1x0, with `z_o[0]` taking the last two lines and `z_o[1]` the first three, the array gives `z_o[0]` = minterms {4,7} and `z_o[1]` = minterms {1,3,4}.
- R10: Rewriting the rows replaces the function completely. No part of the earlier function remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all connections |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Row address: AND rows 0-3, OR rows 4-5 |
| cfg_data_i | input | 6 | Row data |
| x_i | input | 3 | Logic inputs x0..x2 |
| z_o | output | 2 | Logic outputs z0, z1 |

## Verification
Any bad connection bit is visible at the outputs, but only for input values where the affected product line decides the result. A bad stored bit can stay hidden for a whole configuration if no applied input selects that line. For this reason every configuration is swept over all eight input values right after each write. A decode error shows up one cycle after the write edge, either as a wrong row taking the data or as a write to addresses 6 or 7 changing the function. A missing or early update is caught by sampling both before and after the write edge.

// File: rtl/rt_pla_pkg.sv
package rt_pla_pkg;
  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rt_pla_cfg_decode.sv
module rt_pla_cfg_decode #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 3
) (
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  output logic [N_TERM-1:0] and_we_o,
  output logic [N_OUT-1:0]  or_we_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_and
    assign and_we_o[t] = we_i && (addr_i == AW'(t));
  end
  for (genvar o = 0; o < N_OUT; o++) begin : g_or
    assign or_we_o[o] = we_i && (addr_i == AW'(N_TERM + o));
  end
endmodule

// File: rtl/rt_pla_and_plane.sv
module rt_pla_and_plane
  import rt_pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  localparam int RW    = 2 * N_IN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TERM-1:0] row_we_i,
  input  logic [RW-1:0]     row_data_i,
  input  logic [N_IN-1:0]   x_i,
  output logic [N_TERM-1:0] term_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [RW-1:0] row_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         row_q <= '0;
      else if (row_we_i[t]) row_q <= row_data_i;
    end

    always_comb begin
      term_o[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        case (lit_code_e'(row_q[2*i +: 2]))
          LIT_NONE: ;
          LIT_TRUE: term_o[t] = term_o[t] & x_i[i];
          LIT_COMP: term_o[t] = term_o[t] & ~x_i[i];
          default:  term_o[t] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rt_pla_or_plane.sv
module rt_pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_OUT-1:0]  row_we_i,
  input  logic [N_TERM-1:0] row_data_i,
  input  logic [N_TERM-1:0] term_i,
  output logic [N_OUT-1:0]  z_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          sel_q <= '0;
      else if (row_we_i[o]) sel_q <= row_data_i;
    end

    assign z_o[o] = |(sel_q & term_i);
  end
endmodule

// File: rtl/rt_pla.sv
module rt_pla
  import rt_pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int DW    = max2(2 * N_IN, N_TERM),
  localparam int AW    = $clog2(N_TERM + N_OUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_data_i,
  input  logic [N_IN-1:0]  x_i,
  output logic [N_OUT-1:0] z_o
);
  logic [N_TERM-1:0] and_we;
  logic [N_OUT-1:0]  or_we;
  logic [N_TERM-1:0] term;

  rt_pla_cfg_decode #(.N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_dec (
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .and_we_o (and_we),
    .or_we_o  (or_we)
  );

  rt_pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_we_i   (and_we),
    .row_data_i (cfg_data_i[2*N_IN-1:0]),
    .x_i        (x_i),
    .term_o     (term)
  );

  rt_pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_we_i   (or_we),
    .row_data_i (cfg_data_i[N_TERM-1:0]),
    .term_i     (term),
    .z_o        (z_o)
  );
endmodule

// File: rtl/rt_pla_chk.sv
module rt_pla_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [AW-1:0]     cfg_addr_i,
  input logic [N_TERM-1:0] or_data_i,
  input logic [N_IN-1:0]   x_i,
  input logic [N_OUT-1:0]  z_o
);
  // R1: first cycle out of reset shows the cleared array
  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (z_o == '0));

  // R7 / R8: no write in the last cycle and steady inputs give steady outputs
  assert_hold_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(x_i)) |-> $stable(z_o));

  // R6: writes past the last row leave the function untouched
  assert_unmapped_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (int'(cfg_addr_i) >= N_TERM + N_OUT))
      |=> (!$stable(x_i) || $stable(z_o)));

  // R5: emptying an OR row silences that output from the next cycle
  for (genvar o = 0; o < N_OUT; o++) begin : g_empty
    assert_empty_or_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && (cfg_addr_i == AW'(N_TERM + o)) && (or_data_i == '0))
        |=> (z_o[o] == 1'b0));
  end
endmodule

bind rt_pla rt_pla_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .or_data_i  (cfg_data_i[N_TERM-1:0]),
  .x_i        (x_i),
  .z_o        (z_o)
);

// File: tb/rt_pla_tb.sv
`timescale 1ns/1ps
module rt_pla_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [5:0] cfg_data = '0;
  logic [2:0] x = '0;
  logic [1:0] z;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [5:0] m_and [4];
  logic [3:0] m_or  [2];

  always #2 clk = ~clk;

  rt_pla u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .x_i(x), .z_o(z)
  );

  function automatic logic [1:0] model(input logic [2:0] xv);
    logic [3:0] p;
    logic [1:0] r;
    for (int t = 0; t < 4; t++) begin
      p[t] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        case (m_and[t][2*i +: 2])
          2'b01: p[t] = p[t] & xv[i];
          2'b10: p[t] = p[t] & ~xv[i];
          2'b11: p[t] = 1'b0;
          default: ;
        endcase
      end
    end
    for (int o = 0; o < 2; o++) r[o] = |(m_or[o] & p);
    return r;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: x=%0d z=%b expected %b", req, x, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < 4; t++) m_and[t] = '0;
    for (int o = 0; o < 2; o++) m_or[o] = '0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 8; v++) begin
      x = 3'(v);
      #1;
      chk(req, z, model(x));
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (a < 3'd4)       m_and[a] = d;
    else if (a < 3'd6)  m_or[a - 3'd4] = d[3:0];
  endtask

  task automatic sum_of(input logic [7:0] m0, input logic [7:0] m1, input string req);
    for (int v = 0; v < 8; v++) begin
      x = 3'(v);
      #1;
      chk(req, z, {m1[v], m0[v]});
    end
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    sweep("R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    sweep("R1 after release");

    // reference configuration: x2 field [5:4], x1 [3:2], x0 [1:0]
    wr(3'd0, 6'b10_10_01);
    wr(3'd1, 6'b10_01_01);
    wr(3'd2, 6'b01_10_10);
    wr(3'd3, 6'b01_01_01);
    wr(3'd4, 6'b00_1100);
    wr(3'd5, 6'b00_0111);
    sweep("R2 R9 model");
    sum_of(8'b1001_0000, 8'b0001_1010, "R9 minterms");

    // R7: value visible only after the write edge
    x = 3'd4;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_data = 6'b0;
    #1;
    chk("R7 before edge", z, 2'b11);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    m_or[0] = 4'b0;
    chk("R7 after edge", z, 2'b10);
    sweep("R5 empty row");

    // R8: output follows inputs without a clock edge
    @(negedge clk);
    x = 3'd1; #0.2;
    chk("R8 comb", z, 2'b10);
    x = 3'd2; #0.2;
    chk("R8 comb", z, 2'b00);

    // second function: z0 = x0' + x2, z1 = 1
    wr(3'd0, 6'b00_00_00);
    wr(3'd1, 6'b01_01_11);
    wr(3'd2, 6'b00_00_10);
    wr(3'd3, 6'b01_00_00);
    wr(3'd4, 6'b00_1100);
    wr(3'd5, 6'b00_0011);
    sweep("R10 reprogram");
    sum_of(8'b1111_0101, 8'b1111_1111, "R3 R10 truth");

    // R4: only the killed line feeds z1
    wr(3'd5, 6'b00_0010);
    sum_of(8'b1111_0101, 8'b0000_0000, "R4 kill");

    // R6: unmapped addresses ignored; upper bits of OR write ignored
    wr(3'd6, 6'b111111);
    wr(3'd7, 6'b000000);
    sweep("R6 unmapped");
    sum_of(8'b1111_0101, 8'b0000_0000, "R6 unmapped truth");
    wr(3'd5, 6'b11_0001);
    sum_of(8'b1111_0101, 8'b1111_1111, "R6 OR data width");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #0.5 rst_ni = 1'b0;
    model_clear();
    #0.5;
    sweep("R1 mid-run reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    sweep("R1 after second release");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule